// File: doc/BRIEF.md
# Single-Bank USB Endpoint Handshake Controller

This block holds the control flags, the data toggle and an eight-byte packet buffer for one USB device endpoint that has a single buffer bank. Firmware fills the buffer through a byte-write strobe and hands the packet over with an arm strobe. It then watches the ready, transmit-done and setup-pending flags. The serial engine presents decoded token events (IN, OUT, SETUP) and the host's reply to a data packet (ACK or timeout). In return the block produces the handshake or data PID to send and streams the packet bytes one per cycle.

A completed transmission raises a transmit-done flag. Only firmware clears it, and it keeps the endpoint interrupt high. The ready flag is separate and is released by the device as soon as the host acknowledges, so firmware can arm the next packet before it acknowledges the completion. A received SETUP raises a setup-pending flag. While that flag is set, every OUT data packet is refused with NAK. A SETUP also forces the next data packet to DATA1. If the host does not answer, the packet stays armed and is sent again unchanged on the next IN token. Tokens with the reserved code are ignored.

The controller is a three-state machine. IDLE answers tokens. SEND streams buffer bytes. WAIT_HOST waits for the host's reply. The named transitions are:
- IDLE to SEND: an IN token arrives with a non-empty packet armed.
- IDLE to WAIT_HOST: an IN token arrives with a zero-length packet armed.
- SEND to WAIT_HOST: the last byte has been streamed.
- WAIT_HOST to IDLE on host ACK: the packet is released.
- WAIT_HOST to IDLE on timeout: the packet is kept for a resend.

Every other token is answered in IDLE, and the machine stays in IDLE.

Top module: `ep_handshake_ctrl`

## Requirements
- R1: While `pkt_ready` is 1, firmware byte writes are ignored and `fill_count` does not change.
- R2: While `pkt_ready` is 0, each `fw_wr_en` pulse appends `fw_wr_data` to the buffer and increments `fill_count`. A `fw_arm` pulse sets `pkt_ready`, which firmware can read.
- R3: An IN token (`tok_kind` 0) with `pkt_ready` set is answered in the next cycle. `resp_valid` goes high with `resp_code` DATA0 (0) or DATA1 (1), and in that same cycle the first buffered byte appears. Byte i follows i cycles later with `tx_valid` high, and `tx_last` marks the final byte. A zero-length packet streams no bytes.
- R4: A host ACK while the block waits for the host sets `tx_done`, clears `pkt_ready`, empties the buffer (`fill_count` 0) and flips the data toggle.
- R5: `tx_done` stays set until firmware pulses `fw_clr_done`. `irq` is high exactly while `tx_done` or `setup_pend` is set.
- R6: A SETUP token (`tok_kind` 2) is answered with ACK (`resp_code` 3) and sets `setup_pend`. The next data packet sent uses DATA1.
- R7: An OUT token (`tok_kind` 1) is answered with NAK (`resp_code` 2) while `setup_pend` is set. After `fw_clr_setup` clears the flag, it is answered with ACK.
- R8: An IN token with `pkt_ready` clear is answered with NAK, and `fill_count`, `pkt_ready` and `tx_done` are left unchanged.
- R9: The buffer holds 8 bytes. Writes beyond 8 are dropped, and `fill_count` stays at 8.
- R10: A host timeout leaves `pkt_ready`, `fill_count` and the toggle unchanged. The next IN token resends the same bytes with the same data PID.
- R11: After reset all flags are clear, `fill_count` is 0, `irq` is low, no response or byte is driven, and the first data PID is DATA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_wr_en | input | 1 | Firmware byte write strobe |
| fw_wr_data | input | 8 | Byte to append to the buffer |
| fw_arm | input | 1 | Firmware pulse: packet is ready to send |
| fw_clr_done | input | 1 | Firmware pulse: clear transmit-done |
| fw_clr_setup | input | 1 | Firmware pulse: clear setup-pending |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token kind: 0 IN, 1 OUT, 2 SETUP, 3 reserved |
| host_ack | input | 1 | Host acknowledged the data packet |
| host_timeout | input | 1 | Host did not answer the data packet |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_code | output | 2 | 0 DATA0, 1 DATA1, 2 NAK, 3 ACK |
| tx_valid | output | 1 | Packet byte valid |
| tx_byte | output | 8 | Packet byte |
| tx_last | output | 1 | Final byte of the packet |
| pkt_ready | output | 1 | Packet armed flag |
| tx_done | output | 1 | Transmit-complete flag |
| setup_pend | output | 1 | Setup-pending flag |
| fill_count | output | 4 | Bytes currently in the buffer |
| irq | output | 1 | Endpoint interrupt |

## Verification
Each response, and each effect of a firmware strobe on the flags or the fill count, is registered once. The bench therefore drives every stimulus at a falling edge and samples its result at the very next falling edge. The streamed bytes follow the response at one byte per cycle, so byte i is sampled i falling edges after the response. The host reply is driven only after the last byte has been sampled, and its effect on the flags is checked one falling edge later. Packet lengths 0 to 9 are swept, and every expected byte is computed from its length and position.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

    typedef enum logic [1:0] {
        TOK_IN    = 2'd0,
        TOK_OUT   = 2'd1,
        TOK_SETUP = 2'd2,
        TOK_RSVD  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        RSP_DATA0 = 2'd0,
        RSP_DATA1 = 2'd1,
        RSP_NAK   = 2'd2,
        RSP_ACK   = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SEND      = 2'd1,
        ST_WAIT_HOST = 2'd2
    } st_e;

endpackage

// File: rtl/ep_hs_fifo.sv
module ep_hs_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          lock,
    input  logic          flush,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count
);

    logic                      wr_ok;
    logic [DEPTH-1:0][DW-1:0]  slots;

    assign wr_ok = wr_en && !lock && (count != CW'(DEPTH));

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DW-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_ok && count == CW'(g)) begin
                slot_q <= wr_data;
            end
        end
        assign slots[g] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (flush) begin
            count <= '0;
        end else if (wr_ok) begin
            count <= count + CW'(1);
        end
    end

    assign rd_data = slots[rd_idx];

    AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !flush) |=> $stable(count)); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && count == CW'(DEPTH) && !flush) |=> (count == CW'(DEPTH))); // R9

endmodule

// File: rtl/ep_hs_flags.sv
module ep_hs_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic fw_arm,
    input  logic fw_clr_done,
    input  logic fw_clr_setup,
    input  logic ev_ack,
    input  logic ev_setup,
    output logic ready,
    output logic txdone,
    output logic setup,
    output logic toggle
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready  <= 1'b0;
            txdone <= 1'b0;
            setup  <= 1'b0;
            toggle <= 1'b0;
        end else begin
            if (ev_ack) begin
                ready <= 1'b0;
            end else if (fw_arm) begin
                ready <= 1'b1;
            end

            if (ev_ack) begin
                txdone <= 1'b1;
            end else if (fw_clr_done) begin
                txdone <= 1'b0;
            end

            if (ev_setup) begin
                setup <= 1'b1;
            end else if (fw_clr_setup) begin
                setup <= 1'b0;
            end

            if (ev_setup) begin
                toggle <= 1'b1;
            end else if (ev_ack) begin
                toggle <= ~toggle;
            end
        end
    end

    AST_TXDONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (txdone && !fw_clr_done) |=> txdone); // R5

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ack |=> (txdone && !ready)); // R4

    AST_ACK_FLIPS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ack && !ev_setup) |=> (toggle != $past(toggle))); // R4

    AST_SETUP_FORCES_DATA1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_setup |=> (toggle && setup)); // R6

endmodule

// File: rtl/ep_hs_fsm.sv
module ep_hs_fsm
    import ep_hs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_valid,
    input  logic [1:0]    tok_kind,
    input  logic          host_ack,
    input  logic          host_timeout,
    input  logic          ready,
    input  logic          setup,
    input  logic          toggle,
    input  logic [CW-1:0] fill,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_idx,
    output logic          resp_valid,
    output logic [1:0]    resp_code,
    output logic          tx_valid,
    output logic [DW-1:0] tx_byte,
    output logic          tx_last,
    output logic          ev_ack,
    output logic          ev_setup
);

    st_e           st_q, st_n;
    logic [CW-1:0] idx_q, idx_n;
    logic          rv_n;
    rsp_e          rc_q, rc_n;
    tok_e          tok;
    logic          at_end;

    assign tok    = tok_e'(tok_kind);
    assign at_end = (idx_q == fill - CW'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            idx_q      <= '0;
            resp_valid <= 1'b0;
            rc_q       <= RSP_DATA0;
        end else begin
            st_q       <= st_n;
            idx_q      <= idx_n;
            resp_valid <= rv_n;
            rc_q       <= rc_n;
        end
    end

    // next state and events
    always_comb begin
        st_n     = st_q;
        idx_n    = idx_q;
        rv_n     = 1'b0;
        rc_n     = rc_q;
        ev_ack   = 1'b0;
        ev_setup = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (tok_valid) begin
                    unique case (tok)
                        TOK_IN: begin
                            rv_n = 1'b1;
                            if (ready) begin
                                rc_n  = toggle ? RSP_DATA1 : RSP_DATA0;
                                idx_n = '0;
                                st_n  = (fill == '0) ? ST_WAIT_HOST : ST_SEND;
                            end else begin
                                rc_n = RSP_NAK;
                            end
                        end
                        TOK_OUT: begin
                            rv_n = 1'b1;
                            rc_n = setup ? RSP_NAK : RSP_ACK;
                        end
                        TOK_SETUP: begin
                            rv_n     = 1'b1;
                            rc_n     = RSP_ACK;
                            ev_setup = 1'b1;
                        end
                        default: begin
                            rv_n = 1'b0;
                        end
                    endcase
                end
            end
            ST_SEND: begin
                idx_n = idx_q + CW'(1);
                if (at_end) begin
                    st_n = ST_WAIT_HOST;
                end
            end
            ST_WAIT_HOST: begin
                if (host_ack) begin
                    ev_ack = 1'b1;
                    st_n   = ST_IDLE;
                end else if (host_timeout) begin
                    st_n = ST_IDLE;
                end
            end
            default: begin
                st_n = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        tx_valid  = (st_q == ST_SEND);
        tx_last   = tx_valid && at_end;
        tx_byte   = tx_valid ? rd_data : '0;
        rd_idx    = idx_q[AW-1:0];
        resp_code = rc_q;
    end

    AST_OUT_NAK_WHILE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && tok_valid && tok == TOK_OUT && setup)
        |=> (resp_valid && resp_code == RSP_NAK)); // R7

    AST_IN_NAK_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && tok_valid && tok == TOK_IN && !ready)
        |=> (resp_valid && resp_code == RSP_NAK && st_q == ST_IDLE)); // R8

    AST_SEND_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (idx_q < fill)); // R3

    AST_TIMEOUT_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_HOST && !host_ack && host_timeout) |=> (ready && st_q == ST_IDLE)); // R10

endmodule

// File: rtl/ep_handshake_ctrl.sv
module ep_handshake_ctrl #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fw_wr_en,
    input  logic [DW-1:0] fw_wr_data,
    input  logic          fw_arm,
    input  logic          fw_clr_done,
    input  logic          fw_clr_setup,
    input  logic          tok_valid,
    input  logic [1:0]    tok_kind,
    input  logic          host_ack,
    input  logic          host_timeout,
    output logic          resp_valid,
    output logic [1:0]    resp_code,
    output logic          tx_valid,
    output logic [DW-1:0] tx_byte,
    output logic          tx_last,
    output logic          pkt_ready,
    output logic          tx_done,
    output logic          setup_pend,
    output logic [CW-1:0] fill_count,
    output logic          irq
);

    logic          ev_ack;
    logic          ev_setup;
    logic          toggle;
    logic [AW-1:0] rd_idx;
    logic [DW-1:0] rd_data;

    ep_hs_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fw_wr_en),
        .wr_data (fw_wr_data),
        .lock    (pkt_ready),
        .flush   (ev_ack),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .count   (fill_count)
    );

    ep_hs_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .fw_arm       (fw_arm),
        .fw_clr_done  (fw_clr_done),
        .fw_clr_setup (fw_clr_setup),
        .ev_ack       (ev_ack),
        .ev_setup     (ev_setup),
        .ready        (pkt_ready),
        .txdone       (tx_done),
        .setup        (setup_pend),
        .toggle       (toggle)
    );

    ep_hs_fsm #(.DEPTH(DEPTH), .DW(DW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tok_valid    (tok_valid),
        .tok_kind     (tok_kind),
        .host_ack     (host_ack),
        .host_timeout (host_timeout),
        .ready        (pkt_ready),
        .setup        (setup_pend),
        .toggle       (toggle),
        .fill         (fill_count),
        .rd_data      (rd_data),
        .rd_idx       (rd_idx),
        .resp_valid   (resp_valid),
        .resp_code    (resp_code),
        .tx_valid     (tx_valid),
        .tx_byte      (tx_byte),
        .tx_last      (tx_last),
        .ev_ack       (ev_ack),
        .ev_setup     (ev_setup)
    );

    assign irq = tx_done || setup_pend;

    AST_IRQ_HELD_BY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !fw_clr_done) |=> irq); // R5

endmodule

// File: tb/ep_handshake_ctrl_test.sv
module ep_handshake_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fw_wr_en = 1'b0;
    logic [7:0] fw_wr_data = '0;
    logic       fw_arm = 1'b0;
    logic       fw_clr_done = 1'b0;
    logic       fw_clr_setup = 1'b0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = '0;
    logic       host_ack = 1'b0;
    logic       host_timeout = 1'b0;
    logic       resp_valid;
    logic [1:0] resp_code;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       tx_last;
    logic       pkt_ready;
    logic       tx_done;
    logic       setup_pend;
    logic [3:0] fill_count;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int exp_tog = 0;
    logic [7:0] exp_b [8];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ep_handshake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fw_wr_en(fw_wr_en), .fw_wr_data(fw_wr_data),
        .fw_arm(fw_arm), .fw_clr_done(fw_clr_done), .fw_clr_setup(fw_clr_setup),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .host_ack(host_ack),
        .host_timeout(host_timeout), .resp_valid(resp_valid), .resp_code(resp_code),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
        .pkt_ready(pkt_ready), .tx_done(tx_done), .setup_pend(setup_pend),
        .fill_count(fill_count), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // every task starts and ends at a falling edge
    task automatic fw_write(input logic [7:0] b);
        fw_wr_en = 1'b1; fw_wr_data = b;
        @(negedge clk);
        fw_wr_en = 1'b0;
    endtask

    task automatic fw_pulse(input int which);
        if (which == 0) fw_arm = 1'b1;
        if (which == 1) fw_clr_done = 1'b1;
        if (which == 2) fw_clr_setup = 1'b1;
        @(negedge clk);
        fw_arm = 1'b0; fw_clr_done = 1'b0; fw_clr_setup = 1'b0;
    endtask

    task automatic token(input logic [1:0] kind, input int exp_code, input string tag);
        tok_valid = 1'b1; tok_kind = kind;
        @(negedge clk);
        tok_valid = 1'b0;
        chk({tag, " resp_valid"}, int'(resp_valid), 1);
        chk({tag, " resp_code"}, int'(resp_code), exp_code);
    endtask

    task automatic in_packet(input int n, input int pid, input string tag);
        token(2'd0, pid, tag);
        for (int i = 0; i < n; i++) begin
            chk({tag, " R3 tx_valid"}, int'(tx_valid), 1);
            chk({tag, " R3 byte"}, int'(tx_byte), int'(exp_b[i]));
            chk({tag, " R3 tx_last"}, int'(tx_last), (i == n - 1) ? 1 : 0);
            @(negedge clk);
        end
        chk({tag, " R3 stream ended"}, int'(tx_valid), 0);
    endtask

    task automatic host_reply(input bit ack);
        if (ack) host_ack = 1'b1; else host_timeout = 1'b1;
        @(negedge clk);
        host_ack = 1'b0; host_timeout = 1'b0;
    endtask

    function automatic logic [7:0] byte_of(input int len, input int i);
        return 8'((len * 37 + i * 11 + 5) & 255);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 pkt_ready", int'(pkt_ready), 0);
        chk("R11 tx_done", int'(tx_done), 0);
        chk("R11 setup_pend", int'(setup_pend), 0);
        chk("R11 fill_count", int'(fill_count), 0);
        chk("R11 irq", int'(irq), 0);
        chk("R11 resp_valid", int'(resp_valid), 0);
        chk("R11 tx_valid", int'(tx_valid), 0);

        // R8 IN with nothing armed
        token(2'd0, 2, "R8 empty");
        chk("R8 ready kept", int'(pkt_ready), 0);
        chk("R8 fill kept", int'(fill_count), 0);

        // sweep packet lengths 0..9
        for (int len = 0; len < 10; len++) begin
            int kept;
            kept = (len > 8) ? 8 : len;
            for (int i = 0; i < len; i++) begin
                fw_write(byte_of(len, i));
                if (i < 8) exp_b[i] = byte_of(len, i);
            end
            chk("R2/R9 fill_count", int'(fill_count), kept);
            if (len == 2) begin
                token(2'd0, 2, "R8 unarmed");
                chk("R8 fill unchanged", int'(fill_count), 2);
                chk("R8 ready unchanged", int'(pkt_ready), 0);
            end
            fw_pulse(0);
            chk("R2 pkt_ready", int'(pkt_ready), 1);
            fw_write(8'hEE);
            chk("R1 locked write", int'(fill_count), kept);
            if (len == 3) begin
                in_packet(kept, exp_tog, "R10 first try");
                host_reply(1'b0);
                chk("R10 ready kept", int'(pkt_ready), 1);
                chk("R10 fill kept", int'(fill_count), kept);
                chk("R10 no done", int'(tx_done), 0);
                in_packet(kept, exp_tog, "R10 resend");
            end else begin
                in_packet(kept, exp_tog, "R3 packet");
            end
            host_reply(1'b1);
            exp_tog ^= 1;
            chk("R4 tx_done", int'(tx_done), 1);
            chk("R4 ready released", int'(pkt_ready), 0);
            chk("R4 fill cleared", int'(fill_count), 0);
            chk("R5 irq", int'(irq), 1);
            repeat (3) @(negedge clk);
            chk("R5 tx_done sticky", int'(tx_done), 1);
            fw_pulse(1);
            chk("R5 tx_done cleared", int'(tx_done), 0);
            chk("R5 irq low", int'(irq), 0);
        end

        // R6/R7 setup handling (toggle is DATA0 here)
        token(2'd2, 3, "R6 setup");
        chk("R6 setup_pend", int'(setup_pend), 1);
        chk("R5 irq from setup", int'(irq), 1);
        token(2'd1, 2, "R7 out nak 1");
        token(2'd1, 2, "R7 out nak 2");
        fw_pulse(2);
        chk("R7 setup cleared", int'(setup_pend), 0);
        chk("R5 irq cleared", int'(irq), 0);
        token(2'd1, 3, "R7 out ack");
        exp_tog = 1;
        for (int i = 0; i < 2; i++) begin
            exp_b[i] = byte_of(20, i);
            fw_write(exp_b[i]);
        end
        fw_pulse(0);
        in_packet(2, 1, "R6 data1");
        host_reply(1'b1);
        // arm next packet before acknowledging the completion
        exp_b[0] = 8'h3C;
        fw_write(8'h3C);
        fw_pulse(0);
        chk("R5 done kept while rearming", int'(tx_done), 1);
        fw_pulse(1);
        in_packet(1, 0, "R4 toggled back");
        host_reply(1'b1);
        chk("R4 final done", int'(tx_done), 1);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule